// File: doc/BRIEF.md
# Delayed-Commit Register File

This block is the general-purpose register store of a small pipelined processor. It holds sixteen 16-bit registers. It has two combinational read ports and a single write channel, and that channel works in one of two modes. An ordinary write lands at the clock edge that ends its instruction. A reader of the same register in that cycle gets the new value through a bypass path.

The second mode is a late move. The instruction copies the register addressed on read port A into the write-target register, but the copy does not land at its own edge. The value waits in a one-entry holding slot. It lands at the edge that ends the next valid instruction, after that instruction has read its operands straight from the storage array. The held value is never bypassed to any reader.

Two late moves in a row, `r0 <- r1` then `r1 <- r0`, therefore exchange the two registers while using only one write port. An interrupt-hold output stays high for as long as a value waits in the slot, so the pair cannot be split by an interrupt. Instructions advance only on cycles where `instr_valid` is high.

The holding slot is a two-state machine:
- **SLOT_EMPTY**: no value waits.
- **SLOT_ARMED**: a value and its target address wait.

Its transitions are:
- **ARM** (SLOT_EMPTY to SLOT_ARMED): a late move is accepted.
- **RE_ARM** (SLOT_ARMED to SLOT_ARMED): a late move is accepted while the slot is armed. The old value lands and the new one is captured in the same cycle.
- **DRAIN** (SLOT_ARMED to SLOT_EMPTY): any other valid instruction arrives, and the waiting value lands.
- **HOLD** (either state to itself): a cycle without `instr_valid`.

Top module: `dcrf_top`

## Requirements
- R1: While `rst_n` is low and after its release, every register reads 0x0000 and `irq_hold` is low.
- R2: Each read port returns the register it addresses, combinationally, in the same cycle as the address. The two ports work independently.
- R3: A valid cycle with `wr_en`=1 and `wr_late`=0 writes `wr_data` to register `wr_addr` at that cycle's rising edge. In that same cycle, a read port addressing `wr_addr` returns `wr_data` instead of the stored value.
- R4: A valid cycle with `wr_en`=1 and `wr_late`=1 is a late move. It captures the stored value of the register addressed by `rd_a_addr` in that cycle, taken from the array and not from any held value, as the value for register `wr_addr`. `wr_data` is ignored in this mode.
- R5: A late-move value is not visible to reads during the next valid instruction. It is written into the array at the rising edge that ends that next valid cycle.
- R6: Cycles with `instr_valid` low change no register and do not advance the holding slot, even when `wr_en` is high.
- R7: `irq_hold` is high exactly while a late-move value waits in the slot. It rises at the edge ending the late move and falls at the edge where the value lands, unless a new late move is captured at that same edge.
- R8: When a late move follows a late move, the earlier value lands and the new value is captured at the same edge, using pre-landing read data. The sequence `r0<-r1`, `r1<-r0` exchanges r0 and r1.
- R9: If an ordinary write and a landing late-move value target the same register at the same edge, the register takes the ordinary write's data.
- R10: With `wr_en` low, `wr_late` and `wr_data` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction reads and writes in this cycle |
| rd_a_addr | input | 4 | Read port A address; also the source of a late move |
| rd_b_addr | input | 4 | Read port B address |
| rd_a_data | output | 16 | Read port A data |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | The instruction writes a register |
| wr_late | input | 1 | 1 = late move, 0 = ordinary write |
| wr_addr | input | 4 | Target register |
| wr_data | input | 16 | Data of an ordinary write |
| irq_hold | output | 1 | High while a late-move value waits; interrupts must not be taken |

## Verification
Read data is combinational, so the bench drives each instruction on the falling edge and compares both read ports and `irq_hold` 1 ns later, within the same cycle. An ordinary write is expected in the same cycle on a matching read port, and from the following cycle onward in the array. A late move is expected only after the rising edge that ends the next cycle with `instr_valid` high; any number of idle cycles may fall in between. `irq_hold` is expected one edge after the late move. A reference model in the bench is updated at every rising edge, using the same order: capture first, then landing, then the ordinary write. The next cycle's reads are checked against that model.

// File: rtl/dcrf_pkg.sv
package dcrf_pkg;
    typedef enum logic [0:0] {
        SLOT_EMPTY = 1'b0,
        SLOT_ARMED = 1'b1
    } slot_state_e;
endpackage

// File: rtl/dcrf_slot.sv
// Holding slot for late moves: state machine plus captured address and data.
module dcrf_slot
    import dcrf_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic              wr_en,
    input  logic              wr_late,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] cap_data,
    output logic              land_en,
    output logic [ADDR_W-1:0] land_addr,
    output logic [DATA_W-1:0] land_data,
    output logic              slot_busy
);
    slot_state_e state_q, state_d;
    logic        late_go;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    assign late_go = instr_valid && wr_en && wr_late;

    // next-state: ARM, RE_ARM, DRAIN, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (late_go) state_d = SLOT_ARMED;
            SLOT_ARMED: if (instr_valid && !late_go) state_d = SLOT_EMPTY;
            default:    state_d = SLOT_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // captured payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (late_go) begin
            addr_q <= wr_addr;
            data_q <= cap_data;
        end
    end

    // outputs
    always_comb begin
        slot_busy = (state_q == SLOT_ARMED);
        land_en   = (state_q == SLOT_ARMED) && instr_valid;
        land_addr = addr_q;
        land_data = data_q;
    end

    AST_ARM_AFTER_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        late_go |=> slot_busy); // R7
    AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_busy && instr_valid && !late_go) |=> !slot_busy); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> ($stable(slot_busy) && $stable(land_data) && $stable(land_addr))); // R6
    AST_RE_ARM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        late_go |=> (land_data == $past(cap_data))); // R8
endmodule

// File: rtl/dcrf_array.sv
// Storage array with an ordinary write channel and a landing channel.
module dcrf_array #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             norm_en,
    input  logic [ADDR_W-1:0]                norm_addr,
    input  logic [DATA_W-1:0]                norm_data,
    input  logic                             land_en,
    input  logic [ADDR_W-1:0]                land_addr,
    input  logic [DATA_W-1:0]                land_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        logic hit_norm, hit_land;
        assign hit_norm = norm_en && (norm_addr == ADDR_W'(g));
        assign hit_land = land_en && (land_addr == ADDR_W'(g));
        always_ff @(posedge clk) begin
            if (!rst_n)        regs_q[g] <= '0;
            else if (hit_norm) regs_q[g] <= norm_data;
            else if (hit_land) regs_q[g] <= land_data;
        end
    end

    AST_NORMAL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        norm_en |=> (regs_q[$past(norm_addr)] == $past(norm_data))); // R3
    AST_LATE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (land_en && !(norm_en && norm_addr == land_addr))
        |=> (regs_q[$past(land_addr)] == $past(land_data))); // R5
    AST_NORMAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (land_en && norm_en && norm_addr == land_addr)
        |=> (regs_q[$past(land_addr)] == $past(norm_data))); // R9
endmodule

// File: rtl/dcrf_read.sv
// Combinational read ports with bypass of the ordinary write only.
module dcrf_read #(
    parameter int NUM_REGS  = 16,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 4,
    parameter int NUM_PORTS = 2
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0] rd_addr,
    input  logic                             fwd_en,
    input  logic [ADDR_W-1:0]                fwd_addr,
    input  logic [DATA_W-1:0]                fwd_data,
    output logic [NUM_PORTS-1:0][DATA_W-1:0] rd_data
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        always_comb begin
            if (fwd_en && (fwd_addr == rd_addr[p])) rd_data[p] = fwd_data;
            else                                    rd_data[p] = regs_q[rd_addr[p]];
        end
    end
endmodule

// File: rtl/dcrf_top.sv
module dcrf_top #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 16,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [ADDR_W-1:0] rd_a_addr,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic              wr_late,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq_hold
);
    localparam int NPORT = 2;

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    logic [NPORT-1:0][ADDR_W-1:0]    rd_addr;
    logic [NPORT-1:0][DATA_W-1:0]    rd_data;
    logic              norm_en, land_en, slot_busy;
    logic [ADDR_W-1:0] land_addr;
    logic [DATA_W-1:0] land_data;

    assign norm_en = instr_valid && wr_en && !wr_late;
    assign rd_addr = {rd_b_addr, rd_a_addr};

    dcrf_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .wr_en(wr_en), .wr_late(wr_late), .wr_addr(wr_addr),
        .cap_data(regs_q[rd_a_addr]),
        .land_en(land_en), .land_addr(land_addr), .land_data(land_data),
        .slot_busy(slot_busy)
    );

    dcrf_array #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .norm_en(norm_en), .norm_addr(wr_addr), .norm_data(wr_data),
        .land_en(land_en), .land_addr(land_addr), .land_data(land_data),
        .regs_q(regs_q)
    );

    dcrf_read #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_PORTS(NPORT)) u_read (
        .regs_q(regs_q), .rd_addr(rd_addr),
        .fwd_en(norm_en), .fwd_addr(wr_addr), .fwd_data(wr_data),
        .rd_data(rd_data)
    );

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];
    assign irq_hold  = slot_busy;

    AST_HOLD_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && wr_en && wr_late) |=> irq_hold); // R7
    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid && !irq_hold) |=> $stable(regs_q)); // R6
    AST_NOWE_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_hold && !(instr_valid && wr_en && wr_late)) |=> !irq_hold); // R10
endmodule

// File: tb/dcrf_top_tb.sv
`timescale 1ns/1ps
module dcrf_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [3:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
    logic [15:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, wr_late = 1'b0;
    logic        irq_hold;

    always #2 clk = ~clk;

    dcrf_top u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_late(wr_late), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_hold(irq_hold)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [15:0] ref_r [16];
    bit          ref_pv;
    logic [3:0]  ref_pa;
    logic [15:0] ref_pd;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_read(input bit v, input bit we, input bit lt,
                                             input logic [3:0] wa, input logic [15:0] wd,
                                             input logic [3:0] ra);
        if (v && we && !lt && wa == ra) return wd;
        return ref_r[ra];
    endfunction

    // one cycle: drive at negedge, check 1ns later, update model at posedge
    task automatic step(input bit v, input logic [3:0] a, input logic [3:0] b,
                        input bit we, input bit lt, input logic [3:0] wa,
                        input logic [15:0] wd, input string req);
        logic [15:0] cap;
        @(negedge clk);
        instr_valid = v; rd_a_addr = a; rd_b_addr = b;
        wr_en = we; wr_late = lt; wr_addr = wa; wr_data = wd;
        #1;
        chk({req, " port A"}, rd_a_data, exp_read(v, we, lt, wa, wd, a));
        chk({req, " port B"}, rd_b_data, exp_read(v, we, lt, wa, wd, b));
        chk({req, " R7 irq_hold"}, {15'd0, irq_hold}, {15'd0, ref_pv});
        @(posedge clk);
        cap = ref_r[a];
        if (v) begin
            if (ref_pv) ref_r[ref_pa] = ref_pd;
            if (we && !lt) ref_r[wa] = wd;
            if (we && lt) begin ref_pv = 1; ref_pa = wa; ref_pd = cap; end
            else ref_pv = 0;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        for (int i = 0; i < 16; i++) ref_r[i] = '0;
        ref_pv = 0; ref_pa = '0; ref_pd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R1 hold in reset", {15'd0, irq_hold}, 16'd0);
        chk("R1 read in reset", rd_a_data, 16'd0);
        @(negedge clk); rst_n = 1'b1;
        // R1: every register zero after reset (idle reads)
        for (int i = 0; i < 16; i += 2) step(0, 4'(i), 4'(i + 1), 0, 0, 0, 0, "R1");
        // R3: ordinary writes with same-cycle bypass
        step(1, 0, 1, 1, 0, 0, 16'h1111, "R3");
        step(1, 1, 0, 1, 0, 1, 16'h2222, "R3");
        step(1, 0, 1, 0, 0, 0, 0, "R2");
        // R4/R5/R8: swap r0,r1 with two late moves
        step(1, 1, 0, 1, 1, 0, 16'hDEAD, "R4");
        step(1, 0, 1, 1, 1, 1, 16'hBEEF, "R5 R8");
        step(1, 0, 1, 0, 0, 0, 0, "R5");
        step(1, 0, 1, 0, 0, 0, 0, "R8 swap");
        chk("R8 r0 after swap", ref_r[0], 16'h2222);
        // R6: idle cycles with wr_en high while armed
        step(1, 2, 3, 1, 1, 5, 16'h0, "R4");
        step(0, 5, 2, 1, 0, 5, 16'h7777, "R6");
        step(0, 5, 2, 1, 1, 2, 16'h7777, "R6");
        step(1, 5, 2, 0, 0, 0, 0, "R6");
        step(1, 5, 2, 0, 0, 0, 0, "R5");
        // R9: ordinary write beats landing value
        step(1, 1, 3, 1, 1, 3, 16'h0, "R4");
        step(1, 3, 3, 1, 0, 3, 16'hA5A5, "R9");
        step(1, 3, 4, 0, 0, 0, 0, "R9");
        chk("R9 model r3", ref_r[3], 16'hA5A5);
        // R10: late flag without wr_en
        step(1, 6, 7, 0, 1, 6, 16'h9999, "R10");
        step(1, 6, 7, 0, 0, 0, 0, "R10");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 9);
            step(r != 0, 4'($urandom), 4'($urandom), r > 3, r > 6,
                 4'($urandom), 16'($urandom), "R2 R3 R5 R8 random");
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule